// File: doc/BRIEF.md
# Bit-6 Channel Swizzle Unit

This unit turns a description of the memory controller's channel setup into an address swizzle rule. It then applies that rule to every tiled access that passes through it. With dual-channel interleaving, the channel is picked partly by address bit 6. A tiled walk also flips the channel when certain higher bits change. For this reason, bit 6 of a tiled address is replaced by the XOR of bit 6 and a group of higher bits. Which bits join depends on the tiling kind (X or Y) and on the interleave mode that was found. Every other address bit passes through unchanged.

The configuration is sampled on a strobe and held until the next strobe. The address path is combinational from the held mode. If a configuration cannot be trusted, the unit reports the mode as unknown. In that case it applies no swizzle and raises a flag asking software to pin the pages of tiled objects.

Top module: `bit6_swizzle_unit`

## Requirements
- R1: After reset the unit applies no swizzle, with `mode_known`=1 and `pin_pages`=0.
- R2: When the channel mode is single channel (`cfg_chan`=0), asymmetric dual channel (1) or the reserved code (3), no swizzle is applied for either tiling, and the mode is known.
- R3: When the channel mode is interleaved (`cfg_chan`=2) and `cfg_xor_off`=1, X-tiled accesses get out bit 6 = a6^a9^a10 and Y-tiled accesses get a6^a9.
- R4: When the mode is interleaved, `cfg_xor_off`=0 and `cfg_hi_sel`=0, X-tiled accesses get a6^a9^a10^a11 and Y-tiled accesses get a6^a9^a11.
- R5: When the mode is interleaved, `cfg_xor_off`=0 and `cfg_hi_sel`=1, X-tiled accesses get a6^a9^a10^a17 and Y-tiled accesses get a6^a9^a17.
- R6: When `cfg_bad` (the configuration read returned all ones) or `cfg_lshape` is set, the mode is unknown. This overrides all other fields. The result is no swizzle, `mode_known`=0 and `pin_pages`=1.
- R7: The configuration fields are captured only at a clock edge where `cfg_load`=1. The new mode is visible from that edge on. Field changes without `cfg_load` have no effect.
- R8: Untiled accesses (`acc_tile`=0) and the reserved tiling code 3 pass the address through unchanged.
- R9: No output bit other than bit 6 ever differs from the input address.
- R10: `out_addr` follows a change of `acc_addr` or `acc_tile` in the same cycle, with no clock edge between.
- R11: `pin_pages` is always the inverse of `mode_known`.

Tiling encoding: `acc_tile` 1 = X, 2 = Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture configuration fields at this edge |
| cfg_chan | input | 2 | Channel addressing mode: 0 single, 1 asymmetric, 2 interleaved, 3 reserved |
| cfg_xor_off | input | 1 | Controller channel XOR randomization disabled |
| cfg_hi_sel | input | 1 | Controller XOR uses bit 17 instead of bit 11 |
| cfg_lshape | input | 1 | L-shaped memory layout in use |
| cfg_bad | input | 1 | Configuration read returned all ones |
| acc_addr | input | ADDR_W | Access address |
| acc_tile | input | 2 | Tiling of the access: 0 none, 1 X, 2 Y, 3 reserved |
| out_addr | output | ADDR_W | Address with bit 6 swizzled |
| mode_known | output | 1 | Held mode is a known one |
| pin_pages | output | 1 | Pages of tiled objects must stay pinned |

## Verification
The situation hardest to reach from the ports is a new configuration at the very edge it is loaded. The bench must show that the old rule still holds while `cfg_load` is high before the edge, and that the new rule holds right after it. To do this, the stimulus changes the fields together with the strobe and samples on both sides of the edge. It also changes the fields with the strobe low to show they are ignored. The L-shape and all-ones overrides are combined with every interleave setting, so the override's priority is exercised rather than assumed.

// File: rtl/swz_pkg.sv
// Shared types of the bit-6 swizzle unit.
// Assumes: encodings below are the port encodings listed in the brief.
package swz_pkg;
    typedef enum logic [1:0] {
        SWZ_NONE  = 2'd0,
        SWZ_BASE  = 2'd1,
        SWZ_ADD11 = 2'd2,
        SWZ_ADD17 = 2'd3
    } swz_mode_e;

    typedef enum logic [1:0] {
        CH_SINGLE = 2'd0,
        CH_ASYM   = 2'd1,
        CH_INTLV  = 2'd2,
        CH_RSVD   = 2'd3
    } chan_mode_e;

    typedef enum logic [1:0] {
        TL_NONE = 2'd0,
        TL_X    = 2'd1,
        TL_Y    = 2'd2,
        TL_RSVD = 2'd3
    } tile_e;

    typedef struct packed {
        swz_mode_e mode;
        logic      known;
    } swz_state_t;
endpackage

// File: rtl/swz_mode_decode.sv
// Derives the swizzle mode from the raw configuration fields.
// Assumes: an untrustworthy configuration (bad read or L-shape) wins over
// every other field and maps to an unknown mode with no swizzle.
module swz_mode_decode
    import swz_pkg::*;
(
    input  logic [1:0] chan,
    input  logic       xor_off,
    input  logic       hi_sel,
    input  logic       lshape,
    input  logic       bad,
    output swz_state_t st
);
    // Purpose: pick mode and known flag from the fields.
    always_comb begin
        st.mode  = SWZ_NONE;
        st.known = 1'b1;
        if (bad || lshape) begin
            st.mode  = SWZ_NONE;
            st.known = 1'b0;
        end else if (chan_mode_e'(chan) == CH_INTLV) begin
            if (xor_off)     st.mode = SWZ_BASE;
            else if (hi_sel) st.mode = SWZ_ADD17;
            else             st.mode = SWZ_ADD11;
        end
    end
endmodule

// File: rtl/swz_mode_reg.sv
// Holds the decoded swizzle state between configuration strobes.
// Assumes: synchronous active-low reset; reset state is known/no swizzle.
module swz_mode_reg
    import swz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  swz_state_t st_in,
    output swz_state_t st_q
);
    // Purpose: capture new state on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= SWZ_NONE;
            st_q.known <= 1'b1;
        end else if (load) begin
            st_q <= st_in;
        end
    end
endmodule

// File: rtl/swz_addr_xform.sv
// Applies the held swizzle mode to one address, combinationally.
// Assumes: ADDR_W exceeds the highest tap position; only SWZ_BIT may change.
module swz_addr_xform
    import swz_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SWZ_BIT = 6,
    parameter int TAP_A   = 9,
    parameter int TAP_B   = 10,
    parameter int TAP_LO  = 11,
    parameter int TAP_HI  = 17
) (
    input  swz_mode_e         mode,
    input  logic [1:0]        tile,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam logic [ADDR_W-1:0] M_A  = ADDR_W'(1) << TAP_A;
    localparam logic [ADDR_W-1:0] M_B  = ADDR_W'(1) << TAP_B;
    localparam logic [ADDR_W-1:0] M_LO = ADDR_W'(1) << TAP_LO;
    localparam logic [ADDR_W-1:0] M_HI = ADDR_W'(1) << TAP_HI;

    logic [ADDR_W-1:0] taps;
    logic              flip;

    // Purpose: select which higher bits fold into the swizzled bit.
    always_comb begin
        taps = '0;
        if (tile_e'(tile) == TL_X || tile_e'(tile) == TL_Y) begin
            unique case (mode)
                SWZ_BASE:  taps = M_A;
                SWZ_ADD11: taps = M_A | M_LO;
                SWZ_ADD17: taps = M_A | M_HI;
                default:   taps = '0;
            endcase
            if (tile_e'(tile) == TL_X && mode != SWZ_NONE)
                taps = taps | M_B;
        end
    end

    // Purpose: parity of the selected taps.
    always_comb flip = ^(addr_in & taps);

    // One output bit per address bit; only the swizzle position may flip.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i == SWZ_BIT) begin : g_swz
            assign addr_out[i] = addr_in[i] ^ flip;
        end else begin : g_pass
            assign addr_out[i] = addr_in[i];
        end
    end
endmodule

// File: rtl/bit6_swizzle_unit.sv
// Top of the bit-6 channel swizzle unit: decode, hold, transform.
// Assumes: configuration fields are stable at the edge where cfg_load is high.
module bit6_swizzle_unit
    import swz_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_chan,
    input  logic              cfg_xor_off,
    input  logic              cfg_hi_sel,
    input  logic              cfg_lshape,
    input  logic              cfg_bad,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_tile,
    output logic [ADDR_W-1:0] out_addr,
    output logic              mode_known,
    output logic              pin_pages
);
    swz_state_t st_next;
    swz_state_t st_held;

    swz_mode_decode u_dec (
        .chan    (cfg_chan),
        .xor_off (cfg_xor_off),
        .hi_sel  (cfg_hi_sel),
        .lshape  (cfg_lshape),
        .bad     (cfg_bad),
        .st      (st_next)
    );

    swz_mode_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_load),
        .st_in (st_next),
        .st_q  (st_held)
    );

    swz_addr_xform #(.ADDR_W(ADDR_W)) u_xf (
        .mode     (st_held.mode),
        .tile     (acc_tile),
        .addr_in  (acc_addr),
        .addr_out (out_addr)
    );

    // Purpose: status outputs from the held state.
    always_comb begin
        mode_known = st_held.known;
        pin_pages  = !st_held.known;
    end
endmodule

// File: rtl/swz_checker.sv
// Property checker for bit6_swizzle_unit, attached by bind below.
module swz_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic [1:0]        cfg_chan,
    input logic              cfg_lshape,
    input logic              cfg_bad,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_tile,
    input logic [ADDR_W-1:0] out_addr,
    input logic              mode_known,
    input logic              pin_pages
);
    localparam logic [ADDR_W-1:0] KEEP = ~(ADDR_W'(1) << 6);

    assert_only_bit6_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_addr ^ acc_addr) & KEEP) == '0);

    assert_untiled_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_tile == 2'd0 || acc_tile == 2'd3) |-> out_addr == acc_addr);

    assert_pin_inverse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pages != mode_known);

    assert_unknown_on_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && (cfg_bad || cfg_lshape)) |=> (pin_pages && !mode_known));

    assert_plain_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !cfg_bad && !cfg_lshape && cfg_chan != 2'd2)
        |=> (mode_known && out_addr == acc_addr));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(mode_known) && $stable(pin_pages)));
endmodule

bind bit6_swizzle_unit swz_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .cfg_chan   (cfg_chan),
    .cfg_lshape (cfg_lshape),
    .cfg_bad    (cfg_bad),
    .acc_addr   (acc_addr),
    .acc_tile   (acc_tile),
    .out_addr   (out_addr),
    .mode_known (mode_known),
    .pin_pages  (pin_pages)
);

// File: tb/sim_bit6_swizzle_unit.sv
module sim_bit6_swizzle_unit;
    localparam int ADDR_W = 32;
    localparam time CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic [1:0]        cfg_chan = 2'd0;
    logic              cfg_xor_off = 1'b0;
    logic              cfg_hi_sel = 1'b0;
    logic              cfg_lshape = 1'b0;
    logic              cfg_bad = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [1:0]        acc_tile = 2'd0;
    logic [ADDR_W-1:0] out_addr;
    logic              mode_known;
    logic              pin_pages;

    int checks = 0;
    int errors = 0;
    int exp_mode = 0;   // 0 none, 1 base, 2 +bit11, 3 +bit17
    bit exp_known = 1'b1;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bit6_swizzle_unit #(.ADDR_W(ADDR_W)) u0 (.*);

    function automatic int mode_of(logic [1:0] ch, logic xo, logic hs, logic ls, logic bd);
        if (bd || ls) return 0;
        if (ch != 2'd2) return 0;
        if (xo) return 1;
        return hs ? 3 : 2;
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(logic [ADDR_W-1:0] a, logic [1:0] t, int m);
        logic [ADDR_W-1:0] r = a;
        logic b = a[6];
        if ((t == 2'd1 || t == 2'd2) && m != 0) begin
            b = b ^ a[9];
            if (t == 2'd1) b = b ^ a[10];
            if (m == 2) b = b ^ a[11];
            if (m == 3) b = b ^ a[17];
        end
        r[6] = b;
        return r;
    endfunction

    task automatic check(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access at the current time and check output plus status.
    task automatic access(string req, logic [ADDR_W-1:0] a, logic [1:0] t);
        acc_addr = a;
        acc_tile = t;
        #1;
        check(req, out_addr, exp_addr(a, t, exp_mode));
        check({req, "/R11 status"}, {30'd0, mode_known, pin_pages}, {30'd0, exp_known, !exp_known});
    endtask

    // Load a configuration: drive at negedge, check old rule before edge.
    task automatic load_cfg(logic [1:0] ch, logic xo, logic hs, logic ls, logic bd);
        @(negedge clk);
        cfg_chan = ch; cfg_xor_off = xo; cfg_hi_sel = hs; cfg_lshape = ls; cfg_bad = bd;
        cfg_load = 1'b1;
        access("R7 pre-edge", $urandom, 2'd1);
        @(negedge clk);
        cfg_load = 1'b0;
        exp_mode = mode_of(ch, xo, hs, ls, bd);
        exp_known = !(ls || bd);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_b16));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        access("R1 reset X", 32'h0000_0640, 2'd1);
        access("R1 reset Y", 32'h0002_0e40, 2'd2);

        // R3 directed
        load_cfg(2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        access("R3 X bit9", 32'h0000_0200, 2'd1);
        access("R3 X bit10", 32'h0000_0400, 2'd1);
        access("R3 Y bit10 ignored", 32'h0000_0400, 2'd2);
        access("R8 untiled", 32'h0000_0600, 2'd0);
        access("R8 reserved tile", 32'hffff_ffff, 2'd3);
        // R7: fields change without strobe, no effect
        @(negedge clk);
        cfg_xor_off = 1'b0; cfg_hi_sel = 1'b1; cfg_bad = 1'b1;
        @(negedge clk);
        access("R7 ignored fields", 32'h0002_0000, 2'd1);
        // R4
        load_cfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        access("R4 X bit11", 32'h0000_0800, 2'd1);
        access("R4 Y bit11", 32'h0000_0800, 2'd2);
        access("R4 bit17 ignored", 32'h0002_0000, 2'd2);
        // R5
        load_cfg(2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
        access("R5 X bit17", 32'h0002_0000, 2'd1);
        access("R5 Y bit17", 32'h0002_0040, 2'd2);
        // R10: address change with no edge
        access("R10 comb A", 32'h0000_0200, 2'd2);
        access("R10 comb B", 32'h0000_0000, 2'd2);
        // R6: overrides with every interleave setting
        for (int k = 0; k < 8; k++) begin
            load_cfg(2'd2, k[0], k[1], !k[2], k[2]);
            access("R6 unknown X", 32'h0002_0e00, 2'd1);
            access("R6 unknown Y", 32'h0002_0a00, 2'd2);
        end
        // R2
        for (int c = 0; c < 4; c++) begin
            if (c == 2) continue;
            load_cfg(c[1:0], 1'b1, 1'b1, 1'b0, 1'b0);
            access("R2 plain X", 32'h0002_0e00, 2'd1);
            access("R2 plain Y", 32'h0002_0a00, 2'd2);
        end
        // Random mix
        for (int n = 0; n < 60; n++) begin
            logic [ADDR_W-1:0] a;
            logic [5:0] r = 6'($urandom);
            load_cfg(r[1:0], r[2], r[3], (r[5:4] == 2'd3), (r[5:4] == 2'd2));
            for (int j = 0; j < 20; j++) begin
                a = $urandom;
                access("R3/R4/R5 random", a, 2'($urandom));
                checks++;
                if (((out_addr ^ a) & ~(32'h40)) != 0) begin
                    errors++;
                    $display("FAIL R9: actual=%h expected=%h", out_addr, a);
                end
            end
        end
        // R1 again after mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_mode = 0; exp_known = 1'b1;
        access("R1 re-reset", 32'h0002_0e40, 2'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule